// File: doc/BRIEF.md
# SPI Master with Clamped Select-to-Clock Delays

This block is a single-target SPI master shift engine. It takes one frame at a time over a valid/ready interface, drives it out on MOSI most significant bit first, and collects MISO into a received word. Software-free configuration inputs select the SCK half-period in system clocks, the clock polarity and phase, and two delays. The lead delay runs from chip-select assertion to the first SCK edge. The trail delay runs from the last SCK edge to chip-select release.

A continue flag travels with each frame. When it is set, chip-select stays low into the next frame. SCK still parks at its idle level for the trail delay plus the lead delay between the two frames. Programming both delays as zero would collapse that pause into what looks like a lost clock cycle. To prevent this, the block raises each delay to at least a quarter of the SCK period, rounded up. The pause is then never shorter than half a period. If the continue flag is set but no frame is waiting, chip-select stays low and SCK stays idle until one arrives. After an ordinary frame, chip-select stays high for at least one full SCK period before the next frame can assert it.

The controller moves through six states:

| State | Behaviour |
|---|---|
| IDLE | Chip-select high; ready for a frame. |
| LEAD | Chip-select low; the lead delay is counting. |
| XFER | SCK is toggling and the frame is shifting. |
| TRAIL | SCK is idle; the trail delay is counting. |
| HOLD | Chip-select low and SCK idle; waiting for a continued frame. |
| GAP | Chip-select high; the minimum deselect time is counting. |

The transitions are:

- IDLE→LEAD on a handshake.
- LEAD→XFER when the lead count ends. The first SCK edge is issued on this transition.
- XFER→TRAIL on the final SCK edge.
- TRAIL→LEAD at the end of the trail count, when the continue flag is set and a frame is offered.
- TRAIL→HOLD at the end of the trail count, when the continue flag is set and no frame is offered.
- TRAIL→GAP at the end of the trail count, when the continue flag is clear.
- HOLD→LEAD on a handshake.
- GAP→IDLE when the deselect count ends.

Top module: `spi_cs_gap_master`

## Requirements
- R1: During and directly after reset, cs_n is 1, sck equals cfg_cpol, rx_valid is 0 and tx_ready is 1.
- R2: Whenever cs_n is high, or no frame is mid-shift, sck sits at the idle level cfg_cpol.
- R3: The number of clk cycles from cs_n falling to the first sck edge equals max(cfg_lead, ceil(D/2)), where D is cfg_div (a cfg_div of 0 acts as 1).
- R4: The number of clk cycles from the last sck edge of a frame to cs_n rising equals max(cfg_trail, ceil(D/2)).
- R5: Each frame makes exactly 2*FRAME_W sck edges, and consecutive edges within a frame are D clk cycles apart.
- R6: MOSI carries tx_data MSB first. It is stable at each sampling edge: the leading edge of each bit when cfg_cpha=0, the trailing edge when cfg_cpha=1.
- R7: MISO is sampled at the same edges and assembled MSB first into rx_data. rx_valid is high for exactly one cycle, starting with the final sck edge of the frame.
- R8: A frame sent with tx_cont=1 followed by an already-waiting frame keeps cs_n low throughout. The gap between the last edge of the first frame and the first edge of the second is effective trail plus effective lead.
- R9: With tx_cont=1 and no frame waiting, cs_n stays low and sck stays idle. The first edge of the late frame comes exactly the effective lead after its handshake.
- R10: After a frame with tx_cont=0, cs_n stays high for at least 2*D clk cycles before falling again.
- R11: tx_ready is 0 from the first sck edge of a frame until its final edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | A frame is offered |
| tx_ready | output | 1 | The engine accepts the offered frame this cycle |
| tx_data | input | FRAME_W | Frame to transmit, MSB first |
| tx_cont | input | 1 | Keep chip-select asserted after this frame |
| cfg_div | input | DIV_W | SCK half-period in clk cycles |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_lead | input | DLY_W | Requested select-to-first-edge delay in clk cycles |
| cfg_trail | input | DLY_W | Requested last-edge-to-release delay in clk cycles |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip-select |
| miso | input | 1 | Serial data in |
| rx_valid | output | 1 | One-cycle pulse: rx_data holds a new frame |
| rx_data | output | FRAME_W | Last received frame |

## Verification
The bench drives both delays at zero in every clock mode and checks that the clamp still produces a nonzero lead, a nonzero trail and an inter-frame pause of at least half a period. A design without the clamp would place the last edge of one frame right against the first edge of the next, which looks like a swallowed SCK cycle. Continued frames are tested two ways: with the next frame already waiting, and with it arriving long after the trail ends. These catch a design that releases chip-select, lets SCK wander while holding, or skips the lead delay on a late frame. Odd dividers test the rounding of the quarter period. A back-to-back pair of ordinary frames checks that the deselect time is not shortened when a frame is already waiting.

// File: rtl/spi_gap_pkg.sv
package spi_gap_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_XFER,
        ST_TRAIL,
        ST_HOLD,
        ST_GAP
    } gap_state_t;
endpackage

// File: rtl/spi_gap_clamp.sv
// Derives effective delays: each delay is at least a quarter SCK period (rounded up).
module spi_gap_clamp #(
    parameter int DIV_W = 8,
    parameter int DLY_W = 8,
    parameter int CNT_W = 10
) (
    input  logic [DIV_W-1:0] div_in,
    input  logic [DLY_W-1:0] lead_in,
    input  logic [DLY_W-1:0] trail_in,
    output logic [DIV_W-1:0] div_nz,
    output logic [CNT_W-1:0] eff_lead,
    output logic [CNT_W-1:0] eff_trail,
    output logic [CNT_W-1:0] gap_len
);
    logic [DIV_W:0]   quarter_w;
    logic [CNT_W-1:0] quarter;
    logic [CNT_W-1:0] lead_w;
    logic [CNT_W-1:0] trail_w;

    always_comb begin
        div_nz    = (div_in == '0) ? DIV_W'(1) : div_in;
        // period = 2*div, so ceil(period/4) = ceil(div/2)
        quarter_w = ({1'b0, div_nz} + (DIV_W+1)'(1)) >> 1;
        quarter   = CNT_W'(quarter_w);
        lead_w    = CNT_W'(lead_in);
        trail_w   = CNT_W'(trail_in);
        eff_lead  = (lead_w  > quarter) ? lead_w  : quarter;
        eff_trail = (trail_w > quarter) ? trail_w : quarter;
        gap_len   = CNT_W'({div_nz, 1'b0});
    end
endmodule

// File: rtl/spi_gap_shreg.sv
// Transmit and receive shift registers, MSB first.
module spi_gap_shreg #(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] load_data,
    input  logic               shift_out,
    input  logic               sample_in,
    input  logic               miso,
    output logic               mosi,
    output logic [FRAME_W-1:0] rx_word
);
    logic [FRAME_W-1:0] tx_q;
    logic [FRAME_W-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= load_data;
        end else if (shift_out) begin
            tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (sample_in) begin
            rx_q <= {rx_q[FRAME_W-2:0], miso};
        end
    end

    assign mosi    = tx_q[FRAME_W-1];
    assign rx_word = rx_q;

    // R6: load and shift never coincide (loads happen only outside XFER)
    a_r6_load_shift_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift_out));
endmodule

// File: rtl/spi_cs_gap_master.sv
module spi_cs_gap_master #(
    parameter int FRAME_W = 8,
    parameter int DIV_W   = 8,
    parameter int DLY_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_valid,
    output logic               tx_ready,
    input  logic [FRAME_W-1:0] tx_data,
    input  logic               tx_cont,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               cfg_cpol,
    input  logic               cfg_cpha,
    input  logic [DLY_W-1:0]   cfg_lead,
    input  logic [DLY_W-1:0]   cfg_trail,
    output logic               sck,
    output logic               mosi,
    output logic               cs_n,
    input  logic               miso,
    output logic               rx_valid,
    output logic [FRAME_W-1:0] rx_data
);
    import spi_gap_pkg::*;

    localparam int CNT_W = ((DLY_W > DIV_W) ? DLY_W : DIV_W) + 2;
    localparam int EC_W  = $clog2(2 * FRAME_W);
    localparam logic [EC_W-1:0] EC_LAST = EC_W'(2 * FRAME_W - 1);

    gap_state_t       state, state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [DIV_W-1:0] hcnt_q;
    logic [EC_W-1:0]  ecnt_q;
    logic             tgl_q, cs_n_q, rx_valid_q, cont_q;

    logic [DIV_W-1:0] div_nz;
    logic [CNT_W-1:0] eff_lead, eff_trail, gap_len;
    logic lead_done, trail_done, gap_done, half_done;
    logic edge_fire, last_edge, leading, sample_en, shift_en, accept;

    spi_gap_clamp #(.DIV_W(DIV_W), .DLY_W(DLY_W), .CNT_W(CNT_W)) clamp_i (
        .div_in   (cfg_div),
        .lead_in  (cfg_lead),
        .trail_in (cfg_trail),
        .div_nz   (div_nz),
        .eff_lead (eff_lead),
        .eff_trail(eff_trail),
        .gap_len  (gap_len)
    );

    always_comb begin
        lead_done  = (cnt_q == eff_lead  - CNT_W'(1));
        trail_done = (cnt_q == eff_trail - CNT_W'(1));
        gap_done   = (cnt_q == gap_len   - CNT_W'(1));
        half_done  = (hcnt_q == div_nz - DIV_W'(1));
        edge_fire  = ((state == ST_LEAD) && lead_done) ||
                     ((state == ST_XFER) && half_done);
        last_edge  = (state == ST_XFER) && half_done && (ecnt_q == EC_LAST);
        leading    = ~ecnt_q[0];
        sample_en  = edge_fire && (leading ^ cfg_cpha);
        shift_en   = edge_fire && !(leading ^ cfg_cpha) &&
                     (ecnt_q != '0) && (ecnt_q != EC_LAST);
        tx_ready   = (state == ST_IDLE) || (state == ST_HOLD) ||
                     ((state == ST_TRAIL) && trail_done && cont_q);
        accept     = tx_valid && tx_ready;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_LEAD;
            ST_LEAD:  if (lead_done) state_nx = ST_XFER;
            ST_XFER:  if (last_edge) state_nx = ST_TRAIL;
            ST_TRAIL: if (trail_done) begin
                          if (!cont_q)      state_nx = ST_GAP;
                          else if (accept)  state_nx = ST_LEAD;
                          else              state_nx = ST_HOLD;
                      end
            ST_HOLD:  if (accept) state_nx = ST_LEAD;
            ST_GAP:   if (gap_done) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // timing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hcnt_q <= '0;
            ecnt_q <= '0;
        end else begin
            cnt_q  <= (state_nx != state) ? '0 : cnt_q + CNT_W'(1);
            hcnt_q <= ((state == ST_XFER) && !half_done) ? hcnt_q + DIV_W'(1) : '0;
            if (state_nx == ST_LEAD && state != ST_LEAD) ecnt_q <= '0;
            else if (edge_fire)                           ecnt_q <= ecnt_q + EC_W'(1);
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgl_q      <= 1'b0;
            cs_n_q     <= 1'b1;
            rx_valid_q <= 1'b0;
            cont_q     <= 1'b0;
        end else begin
            cs_n_q     <= (state_nx == ST_IDLE) || (state_nx == ST_GAP);
            rx_valid_q <= last_edge;
            if (accept)         cont_q <= tx_cont;
            if (state == ST_IDLE) tgl_q <= 1'b0;
            else if (edge_fire)   tgl_q <= ~tgl_q;
        end
    end

    spi_gap_shreg #(.FRAME_W(FRAME_W)) shreg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_data(tx_data),
        .shift_out(shift_en),
        .sample_in(sample_en),
        .miso     (miso),
        .mosi     (mosi),
        .rx_word  (rx_data)
    );

    assign sck      = cfg_cpol ^ tgl_q;
    assign cs_n     = cs_n_q;
    assign rx_valid = rx_valid_q;

    // R2: deselected means clock parked at idle
    a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sck == cfg_cpol));
    // R7: receive strobe is a single-cycle pulse
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R9: waiting for a continued frame keeps select low and clock idle
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> (!cs_n && sck == cfg_cpol));
    // R11: no frame accepted while one is being clocked
    a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER || state == ST_LEAD) |-> !tx_ready);
    // R10: a release of select lasts more than one cycle
    a_r10_release_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> cs_n);
    // R3: no clock movement before the lead count ends
    a_r3_lead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD && !lead_done) |=> $stable(tgl_q));
endmodule

// File: tb/spi_cs_gap_master_tb.sv
`timescale 1ns/1ps
module spi_cs_gap_master_tb_top;
    localparam int FW = 8;
    localparam int NE = 2 * FW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic tx_valid = 1'b0, tx_cont = 1'b0, miso = 1'b0;
    logic [FW-1:0] tx_data = '0;
    logic [7:0] cfg_div = 8'd2, cfg_lead = '0, cfg_trail = '0;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic tx_ready, sck, mosi, cs_n, rx_valid;
    logic [FW-1:0] rx_data;

    spi_cs_gap_master #(.FRAME_W(FW), .DIV_W(8), .DLY_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_cont(tx_cont), .cfg_div(cfg_div),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lead(cfg_lead),
        .cfg_trail(cfg_trail), .sck(sck), .mosi(mosi), .cs_n(cs_n),
        .miso(miso), .rx_valid(rx_valid), .rx_data(rx_data));

    always #2.5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    always @(posedge clk) cyc = cyc + 1;

    // recorders
    int edge_cyc [64];
    int nedge, nrx, n_fall, n_rise, cs_fall_cyc, rise1_cyc, acc_cyc;
    int idle_bad, busy_bad, bi;
    logic [FW-1:0] rx_hist [4];
    logic [FW-1:0] mo_hist [4];
    int rxv_cyc [4];
    logic [FW-1:0] mosi_cap, slv;
    logic prev_sck = 1'b0, prev_cs = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !cs_n) begin cs_fall_cyc = cyc; n_fall++; end
            if (!prev_cs && cs_n) begin
                if (n_rise == 0) rise1_cyc = cyc;
                n_rise++;
            end
            if (sck !== prev_sck) begin
                if (nedge < 64) edge_cyc[nedge] = cyc;
                if ((prev_sck == cfg_cpol) ^ cfg_cpha) begin
                    mosi_cap = {mosi_cap[FW-2:0], mosi};
                    bi = (bi + 1) % FW;
                    miso = slv[FW-1-bi];
                end
                nedge++;
            end
            if (rx_valid) begin
                if (nrx < 4) begin
                    rx_hist[nrx] = rx_data; mo_hist[nrx] = mosi_cap; rxv_cyc[nrx] = cyc;
                end
                nrx++;
            end
            if ((nedge % NE) != 0 && tx_ready) busy_bad++;
            if ((nedge % NE) == 0 && sck !== cfg_cpol) idle_bad++;
            prev_sck = sck;
            prev_cs  = cs_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int prog, input int div);
        int q = (div + 1) / 2;
        return (prog > q) ? prog : q;
    endfunction

    task automatic setup(input bit pol, input bit pha, input int div,
                         input int ld, input int tr, input logic [FW-1:0] sl);
        @(posedge clk); #1;
        cfg_cpol = pol; cfg_cpha = pha; cfg_div = 8'(div);
        cfg_lead = 8'(ld); cfg_trail = 8'(tr);
        slv = sl; bi = 0; miso = sl[FW-1];
        prev_sck = pol; prev_cs = cs_n;
        nedge = 0; nrx = 0; n_fall = 0; n_rise = 0; idle_bad = 0; busy_bad = 0;
        mosi_cap = '0;
    endtask

    task automatic send(input logic [FW-1:0] d, input bit cont);
        bit hs;
        @(negedge clk);
        tx_valid = 1'b1; tx_data = d; tx_cont = cont;
        do begin
            hs = tx_ready; acc_cyc = cyc + 1;
            @(negedge clk);
        end while (!hs);
        tx_valid = 1'b0;
    endtask

    task automatic wait_done(input int frames);
        int guard = 0;
        while ((nrx < frames || !cs_n) && guard < 5000) begin
            @(negedge clk); guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        chk(sck == cfg_cpol, "R1 sck", sck, cfg_cpol);
        chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_ready == 1'b1, "R1 tx_ready", tx_ready, 1);
        chk(cs_n == 1'b1, "R1 cs_n after", cs_n, 1);
    endtask

    task automatic t_single(input bit pol, input bit pha, input int div, input int ld,
                            input int tr, input logic [FW-1:0] d, input logic [FW-1:0] sl);
        int el = eff(ld, div), et = eff(tr, div), gaps = 0;
        setup(pol, pha, div, ld, tr, sl);
        send(d, 1'b0);
        wait_done(1);
        chk(nedge == NE, "R5 edge count", nedge, NE);
        chk(edge_cyc[0] - cs_fall_cyc == el, "R3 lead", edge_cyc[0] - cs_fall_cyc, el);
        for (int i = 1; i < NE; i++) if (edge_cyc[i] - edge_cyc[i-1] != div) gaps++;
        chk(gaps == 0, "R5 half period", gaps, 0);
        chk(rise1_cyc - edge_cyc[NE-1] == et, "R4 trail", rise1_cyc - edge_cyc[NE-1], et);
        chk(mo_hist[0] == d, "R6 mosi", mo_hist[0], d);
        chk(rx_hist[0] == sl, "R7 rx_data", rx_hist[0], sl);
        chk(nrx == 1 && rxv_cyc[0] == edge_cyc[NE-1], "R7 rx_valid", rxv_cyc[0], edge_cyc[NE-1]);
        chk(idle_bad == 0, "R2 idle level", idle_bad, 0);
        chk(busy_bad == 0, "R11 ready while busy", busy_bad, 0);
    endtask

    task automatic t_cont(input bit pol, input bit pha, input int div, input int ld, input int tr);
        int el = eff(ld, div), et = eff(tr, div);
        setup(pol, pha, div, ld, tr, 8'h3C);
        send(8'hA1, 1'b1);
        send(8'h5E, 1'b0);
        wait_done(2);
        chk(n_fall == 1, "R8 cs stays low", n_fall, 1);
        chk(edge_cyc[NE] - edge_cyc[NE-1] == el + et, "R8 inter-frame gap",
            edge_cyc[NE] - edge_cyc[NE-1], el + et);
        chk(mo_hist[0] == 8'hA1 && mo_hist[1] == 8'h5E, "R8 mosi frames", mo_hist[1], 8'h5E);
        chk(rx_hist[1] == 8'h3C, "R8 rx second", rx_hist[1], 8'h3C);
        chk(idle_bad == 0, "R2 idle in cont", idle_bad, 0);
    endtask

    task automatic t_hold(input int div, input int ld, input int tr);
        int el = eff(ld, div);
        setup(1'b0, 1'b1, div, ld, tr, 8'hC3);
        send(8'h96, 1'b1);
        while (nrx < 1) @(negedge clk);
        repeat (25) @(negedge clk);
        chk(cs_n == 1'b0, "R9 cs held", cs_n, 0);
        chk(sck == cfg_cpol, "R9 sck idle", sck, cfg_cpol);
        send(8'h69, 1'b0);
        wait_done(2);
        chk(n_fall == 1, "R9 single select", n_fall, 1);
        chk(edge_cyc[NE] - acc_cyc == el, "R9 lead after late frame", edge_cyc[NE] - acc_cyc, el);
        chk(mo_hist[1] == 8'h69, "R9 mosi late frame", mo_hist[1], 8'h69);
        chk(idle_bad == 0, "R9 idle while holding", idle_bad, 0);
    endtask

    task automatic t_gap(input int div);
        setup(1'b1, 1'b0, div, 0, 0, 8'h81);
        send(8'h18, 1'b0);
        send(8'hE7, 1'b0);
        wait_done(2);
        chk(n_fall == 2, "R10 reselect", n_fall, 2);
        chk(cs_fall_cyc - rise1_cyc >= 2 * div, "R10 deselect time",
            cs_fall_cyc - rise1_cyc, 2 * div);
        chk(mo_hist[1] == 8'hE7, "R10 second frame", mo_hist[1], 8'hE7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_single(1'b0, 1'b0, 2, 0, 0, 8'hA5, 8'h5A);
        t_single(1'b1, 1'b1, 4, 6, 1, 8'h3C, 8'hF0);
        t_single(1'b0, 1'b1, 3, 0, 7, 8'h81, 8'h7E);
        t_single(1'b1, 1'b0, 1, 3, 0, 8'hFF, 8'h01);
        t_cont(1'b0, 1'b0, 4, 0, 0);
        t_cont(1'b1, 1'b1, 2, 3, 5);
        t_cont(1'b0, 1'b1, 5, 0, 0);
        t_hold(3, 4, 0);
        t_gap(3);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule